// File: doc/BRIEF.md
# DMA Descriptor Queue Register Front-End

This block is the software-facing control layer for a single-channel DMA engine. Software programs a small set of descriptor flags over a simple register port and commits them into a fixed-depth queue. Each committed descriptor receives a 5-bit transfer tag. The engine side pulls descriptors from the queue through a valid/ready handshake. When the engine finishes a transfer, it reports the tag back on a completion input.

Two interrupt causes are kept: "a queued descriptor was taken", which means a slot is free again, and "a transfer ended". Both pass through a mask onto a single registered interrupt line. A 32-bit bitmap records which tags have finished, so one read can drain several completions. Data movement, address generation and memory buses live elsewhere.

The register port is a single-cycle write strobe plus a read strobe. Read data is registered and appears in the cycle after the strobe. Byte addresses are used. Only the offsets listed in the requirements decode; other addresses read as zero.

Top module: `dma_queue_regs`

## Requirements
- R1: After reset: `irq` is 0 and `desc_valid` is 0. The interrupt mask (0x080) reads 3, which masks both causes. The pending register (0x084) reads 0. The next-tag register (0x404) reads 0. The queue-status register (0x408) reads 0.
- R2: The next-tag register returns the tag that the next accepted commit will receive. Each accepted commit advances it by one, and the value wraps from 31 to 0.
- R3: The queue-status register reads 1 when the queue holds DEPTH descriptors and 0 otherwise. Writing a value with bit 0 set to 0x408 commits a descriptor. A commit made while the queue is full is ignored: the tag does not advance and no descriptor is added.
- R4: Descriptors leave the queue in commit order. Each one carries its tag on `desc_id` and the flags value held at commit time on `desc_flags`. The flags value has bit 0 for cyclic, bit 1 for last segment and bit 2 for partial-length reporting. `desc_valid` is asserted only while the control register (0x400) has bit 0 (run) set and bit 1 (hold) clear.
- R5: Each cycle in which `desc_valid` and `desc_ready` are both high removes one descriptor and sets pending bit 0.
- R6: A pulse on `done_valid` sets bit `done_id` of the completion bitmap (0x428) and sets pending bit 1.
- R7: Reading 0x428 returns the bitmap and clears it. A completion arriving in the same cycle as that read is kept. A tag's bit is also cleared when the tag is handed out again.
- R8: Pending bits are write-one-to-clear. A write with a 0 in a bit position leaves that bit unchanged. A new event in the same cycle as a clear wins.
- R9: `irq` is the OR of the pending bits whose mask bit is 0, delayed by one register stage. The source register (0x088) reads the pending bits ANDed with the inverted mask.
- R10: Writing the control register with bit 0 clear empties the queue immediately. Commits made while run is clear are ignored.
- R11: The mask register and the flags register (0x40c, bits 2:0) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read byte address |
| rd_data | output | DW | Read data, valid the cycle after `rd_en` |
| desc_valid | output | 1 | A descriptor is offered to the engine |
| desc_ready | input | 1 | The engine takes the offered descriptor |
| desc_id | output | 5 | Tag of the offered descriptor |
| desc_flags | output | 3 | Flags of the offered descriptor |
| done_valid | input | 1 | A transfer finished |
| done_id | input | 5 | Tag of the finished transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue to its limit and then commits once more. A design that wrapped its pointers there would corrupt the oldest entry or advance the tag. It drives enough commits to carry the tag across 31 to 0 while one completed tag sits unread in the bitmap. A design that failed to clear bits on reissue would report that stale completion. Write-one-to-clear is checked with a zero bit that must not clear, the hold bit must stop the handshake without dropping entries, and an abort must leave the queue empty even after run is set again.

// File: rtl/dma_queue_regs.sv
module dma_queue_regs #(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          desc_valid,
  input  logic          desc_ready,
  output logic [4:0]    desc_id,
  output logic [2:0]    desc_flags,
  input  logic          done_valid,
  input  logic [4:0]    done_id,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_MASK  = AW'(12'h080);
  localparam logic [AW-1:0] A_PEND  = AW'(12'h084);
  localparam logic [AW-1:0] A_SRC   = AW'(12'h088);
  localparam logic [AW-1:0] A_CTRL  = AW'(12'h400);
  localparam logic [AW-1:0] A_TAG   = AW'(12'h404);
  localparam logic [AW-1:0] A_START = AW'(12'h408);
  localparam logic [AW-1:0] A_FLAGS = AW'(12'h40c);
  localparam logic [AW-1:0] A_DONE  = AW'(12'h428);

  logic [1:0]    ctrl, mask, pending, pend_n;
  logic [2:0]    flags;
  logic [4:0]    next_id;
  logic [31:0]   done_bits, done_n;
  logic [PW-1:0] wptr, rptr, wp_n, rp_n;
  logic [CW-1:0] count, cnt_n;
  logic [4:0]    q_id [DEPTH];
  logic [2:0]    q_fl [DEPTH];
  logic          full, commit, take, flush, rd_done;
  logic          unused_bits;

  assign unused_bits = &{1'b0, wr_data[DW-1:3]};
  assign full       = (count == CW'(DEPTH));
  assign commit     = wr_en && wr_addr == A_START && wr_data[0] && ctrl[0] && !full;
  assign flush      = wr_en && wr_addr == A_CTRL && !wr_data[0];
  assign desc_valid = ctrl[0] && !ctrl[1] && (count != '0);
  assign take       = desc_valid && desc_ready;
  assign desc_id    = q_id[rptr];
  assign desc_flags = q_fl[rptr];
  assign rd_done    = rd_en && rd_addr == A_DONE;

  always_comb begin
    cnt_n = count;
    wp_n  = wptr;
    rp_n  = rptr;
    if (flush) begin
      cnt_n = '0;
      wp_n  = '0;
      rp_n  = '0;
    end else begin
      if (commit) wp_n = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (take)   rp_n = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt_n = count + CW'(commit) - CW'(take);
    end
  end

  always_comb begin
    pend_n = pending;
    if (wr_en && wr_addr == A_PEND) pend_n = pend_n & ~wr_data[1:0];
    pend_n = pend_n | {done_valid, take};
  end

  always_comb begin
    done_n = done_bits;
    if (rd_done) done_n = '0;
    if (commit) done_n[next_id] = 1'b0;
    if (done_valid) done_n[done_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      q_id[wptr] <= next_id;
      q_fl[wptr] <= flags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      mask      <= 2'b11;
      pending   <= '0;
      flags     <= '0;
      next_id   <= '0;
      done_bits <= '0;
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL)  ctrl  <= wr_data[1:0];
      if (wr_en && wr_addr == A_MASK)  mask  <= wr_data[1:0];
      if (wr_en && wr_addr == A_FLAGS) flags <= wr_data[2:0];
      if (commit) next_id <= next_id + 5'd1;
      pending   <= pend_n;
      done_bits <= done_n;
      wptr      <= wp_n;
      rptr      <= rp_n;
      count     <= cnt_n;
      irq       <= |(pending & ~mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        A_MASK:  rd_data <= DW'(mask);
        A_PEND:  rd_data <= DW'(pending);
        A_SRC:   rd_data <= DW'(pending & ~mask);
        A_CTRL:  rd_data <= DW'(ctrl);
        A_TAG:   rd_data <= DW'(next_id);
        A_START: rd_data <= DW'(full);
        A_FLAGS: rd_data <= DW'(flags);
        A_DONE:  rd_data <= DW'(done_bits);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_queue_regs_chk.sv
module dma_queue_regs_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic [1:0]    ctrl,
  input logic [1:0]    mask,
  input logic [1:0]    pending,
  input logic [4:0]    next_id,
  input logic [31:0]   done_bits,
  input logic          commit,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic          done_valid,
  input logic [4:0]    done_id,
  input logic          irq
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_id_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> next_id == $past(next_id) + 5'd1);

  p_valid_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> ctrl[0] && !ctrl[1]);

  p_sot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> pending[0]);

  p_eot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> pending[1] && done_bits[$past(done_id)]);

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(pending & ~mask)));
endmodule

bind dma_queue_regs dma_queue_regs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .ctrl(ctrl), .mask(mask),
  .pending(pending), .next_id(next_id), .done_bits(done_bits),
  .commit(commit), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .done_valid(done_valid), .done_id(done_id), .irq(irq)
);

// File: tb/tb_dma_queue_regs.sv
`timescale 1ns/1ps
module tb_dma_queue_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        desc_valid, desc_ready = 1'b0;
  logic [4:0]  desc_id;
  logic [2:0]  desc_flags;
  logic        done_valid = 1'b0;
  logic [4:0]  done_id = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_queue_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_id(desc_id),
    .desc_flags(desc_flags), .done_valid(done_valid), .done_id(done_id), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); d = rd_data; rd_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); desc_ready = 1'b1;
    @(negedge clk); desc_ready = 1'b0;
  endtask

  task automatic complete(input logic [4:0] id);
    @(negedge clk); done_valid = 1'b1; done_id = id;
    @(negedge clk); done_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", irq, 0);
    check("R1 desc_valid", desc_valid, 0);
    rd(12'h080, v); check("R1 mask", v, 3);
    rd(12'h084, v); check("R1 pending", v, 0);
    rd(12'h404, v); check("R1 tag", v, 0);
    rd(12'h408, v); check("R1 status", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(12'h408, 1);
    rd(12'h404, v); check("R10 commit while stopped", v, 0);
    check("R10 no descriptor", desc_valid, 0);
  endtask

  task automatic t_fill();
    logic [31:0] v;
    wr(12'h400, 1);
    wr(12'h080, 0);
    rd(12'h080, v); check("R11 mask readback", v, 0);
    wr(12'h40c, 5);
    rd(12'h40c, v); check("R11 flags readback", v, 5);
    for (int i = 0; i < 4; i++) begin
      wr(12'h40c, i);
      wr(12'h408, 1);
    end
    rd(12'h408, v); check("R3 full status", v, 1);
    wr(12'h408, 1);
    rd(12'h404, v); check("R3 commit when full ignored", v, 4);
    wr(12'h400, 3);
    check("R4 hold stops offer", desc_valid, 0);
    wr(12'h400, 1);
    for (int i = 0; i < 4; i++) begin
      check("R4 valid", desc_valid, 1);
      check("R4 order id", desc_id, i);
      check("R4 flags", desc_flags, i);
      pop();
    end
    check("R3 no extra descriptor", desc_valid, 0);
    rd(12'h408, v); check("R3 not full", v, 0);
    rd(12'h084, v); check("R5 slot taken pending", v, 1);
    check("R9 irq on take", irq, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(12'h084, 2);
    rd(12'h084, v); check("R8 zero bit keeps", v, 1);
    wr(12'h084, 1);
    rd(12'h084, v); check("R8 one bit clears", v, 0);
    check("R9 irq drops", irq, 0);
  endtask

  task automatic t_done();
    logic [31:0] v;
    complete(5'd3);
    complete(5'd17);
    rd(12'h428, v); check("R6 bitmap", v, 32'h0002_0008);
    rd(12'h084, v); check("R6 end pending", v, 2);
    rd(12'h428, v); check("R7 read clears", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(12'h080, 3);
    @(negedge clk);
    check("R9 masked irq", irq, 0);
    rd(12'h088, v); check("R9 masked source", v, 0);
    wr(12'h080, 1);
    rd(12'h088, v); check("R9 source", v, 2);
    check("R9 unmasked irq", irq, 1);
    wr(12'h084, 3);
    wr(12'h080, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    complete(5'd5);
    for (int i = 0; i < 28; i++) begin
      wr(12'h408, 1);
      pop();
    end
    rd(12'h404, v); check("R2 tag wraps", v, 0);
    rd(12'h428, v); check("R7 reissue clears", v, 0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    wr(12'h408, 1);
    wr(12'h408, 1);
    check("R10 queued", desc_valid, 1);
    wr(12'h400, 0);
    check("R10 abort", desc_valid, 0);
    rd(12'h408, v); check("R10 status", v, 0);
    wr(12'h400, 1);
    check("R10 queue empty", desc_valid, 0);
    rd(12'h404, v); check("R2 tag after abort", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fill();
    t_w1c();
    t_done();
    t_mask();
    t_wrap();
    t_flush();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule